// File: doc/BRIEF.md
# Per-CPU Banked GPIO Interrupt Router

This unit takes the per-line edge event pulses and the polarity-corrected level values of a 32-line GPIO bank and distributes them to up to four processors. Every processor owns a private bank of three registers: a sticky edge-cause register, an edge mask and a level mask. An edge pulse on a line marks that line pending in every bank at once, but each processor acknowledges, masks and unmasks on its own. One processor clearing an edge therefore never hides it from another.

Each bank forms a pending vector from its own registers: levels selected by its level mask, plus latched edges selected by its edge mask. The pending vector is folded into one interrupt per group of eight lines, so every processor receives four grouped interrupt outputs. These outputs are registered. The banks sit in a small register window on a simple single-cycle write bus with a combinational read. A block elsewhere decodes the global register copy.

Top module: `percpu_irq_bank`

## Requirements
- R1: While reset is held, every cause, edge mask and level mask register is cleared and every interrupt output is low. Reset is synchronous and active low.
- R2: Byte address decoding within the window. Bits [5:4] select the register kind: 0 is the edge cause, 1 the edge mask, 2 the level mask. Bits [3:2] select the CPU, and bits [1:0] must be zero. CPU n's cause is at n*4, its edge mask at 0x10+n*4 and its level mask at 0x20+n*4. Mask registers read back the value written.
- R3: A one on bit i of `edge_evt` sets cause bit i in every CPU bank on the next clock edge.
- R4: A write to CPU n's cause register clears the bits written as zero and keeps the bits written as one. The cause registers of all other CPUs are unchanged.
- R5: When an edge event and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R6: CPU n's pending vector is (level_in AND its level mask) OR (its cause AND its edge mask). Output `cpu_irq[n*4+g]` is the OR of pending lines 8g to 8g+7.
- R7: An interrupt output changes one clock after its pending condition changes, never in the same cycle.
- R8: Reads at unmapped addresses return zero. Unmapped addresses are offsets 0x30 and up, offsets with bits [1:0] not zero, and CPU indices at or above NUM_CPUS. Writes to unmapped addresses change no register.
- R9: Clearing an edge-mask bit removes the interrupt but keeps the cause bit latched. Setting the mask bit again raises the interrupt again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_evt | input | 32 | One-cycle edge event pulse per line |
| level_in | input | 32 | Polarity-adjusted line levels |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 6 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at bus_addr |
| cpu_irq | output | 16 | Grouped interrupts; bit n*4+g is CPU n, group g |

## Verification
The main routing is exercised with single-line edges in low and high groups, a level source on a middle group, and masks spread over different CPUs. These patterns show whether an event reaches all banks and whether the output lands on the right CPU and group bit. Acknowledge patterns separate a clear that stays in its own bank from one that leaks into another, and a coinciding event and clear shows which of the two wins. Mask-off and mask-on sequences, unmapped and misaligned accesses, and a one-cycle latency probe cover the remaining behaviour. A distinct value written to every mask register proves the address map.

// File: rtl/percpu_irq_pkg.sv
// Shared definitions for the per-CPU interrupt router.
// Assumes a 6-bit byte-addressed window with a 16-byte stride per register kind.
package percpu_irq_pkg;
    localparam int WIN_ADDR_W = 6;
    localparam int CPU_SEL_W  = 2;

    typedef enum logic [1:0] {
        KIND_CAUSE = 2'd0,
        KIND_EMASK = 2'd1,
        KIND_LMASK = 2'd2,
        KIND_NONE  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/pcb_addr_decode.sv
// Window address decoder: splits a byte address into register kind and CPU
// index and flags whether it hits an implemented register.
// Assumes NUM_CPUS <= 4, since the CPU index field is two bits wide.
module pcb_addr_decode
    import percpu_irq_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic [WIN_ADDR_W-1:0] addr,
    output reg_kind_e             kind,
    output logic [CPU_SEL_W-1:0]  cpu,
    output logic                  hit
);
    // Split the address into its fields and qualify the hit.
    always_comb begin
        kind = reg_kind_e'(addr[5:4]);
        cpu  = addr[3:2];
        hit  = (addr[1:0] == 2'b00) && (kind != KIND_NONE) &&
               (32'(cpu) < NUM_CPUS);
    end
endmodule

// File: rtl/pcb_cpu_bank.sv
// One CPU's register bank: a sticky edge cause, an edge mask, a level mask
// and registered grouped interrupt outputs.
// Assumes write enables arrive already decoded for this bank. An event set
// takes priority over a clearing write on the same bit.
module pcb_cpu_bank #(
    parameter int NUM_LINES = 32,
    parameter int GROUP_W   = 8,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  edge_evt,
    input  logic [NUM_LINES-1:0]  level_in,
    input  logic                  wr_cause,
    input  logic                  wr_emask,
    input  logic                  wr_lmask,
    input  logic [NUM_LINES-1:0]  wdata,
    output logic [NUM_LINES-1:0]  cause,
    output logic [NUM_LINES-1:0]  emask,
    output logic [NUM_LINES-1:0]  lmask,
    output logic [NUM_GROUPS-1:0] irq
);
    logic [NUM_LINES-1:0] cause_keep;
    logic [NUM_LINES-1:0] pending;

    // Bits kept by the acknowledge path (a write of zero clears).
    always_comb cause_keep = wr_cause ? (cause & wdata) : cause;

    // Cause register: clear by acknowledge, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= cause_keep | edge_evt;
    end

    // Edge mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        emask <= '0;
        else if (wr_emask) emask <= wdata;
    end

    // Level mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        lmask <= '0;
        else if (wr_lmask) lmask <= wdata;
    end

    // Pending vector from levels and latched edges.
    always_comb pending = (level_in & lmask) | (cause & emask);

    // Registered OR-reduction per group of lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= '0;
        end else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                irq[g] <= |pending[g*GROUP_W +: GROUP_W];
            end
        end
    end
endmodule

// File: rtl/percpu_irq_bank.sv
// Top of the per-CPU interrupt router: decodes the window, replicates one
// register bank per CPU and multiplexes read data.
// Assumes a single-cycle write strobe and a purely combinational read.
module percpu_irq_bank
    import percpu_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_CPUS  = 4,
    parameter int GROUP_W   = 8,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_W,
    localparam int IRQ_W      = NUM_CPUS * NUM_GROUPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  edge_evt,
    input  logic [NUM_LINES-1:0]  level_in,
    input  logic                  bus_wr,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic [NUM_LINES-1:0]  bus_wdata,
    output logic [NUM_LINES-1:0]  bus_rdata,
    output logic [IRQ_W-1:0]      cpu_irq
);
    reg_kind_e              dec_kind;
    logic [CPU_SEL_W-1:0]   dec_cpu;
    logic                   dec_hit;
    logic [NUM_CPUS*NUM_LINES-1:0] cause_flat;
    logic [NUM_CPUS*NUM_LINES-1:0] emask_flat;
    logic [NUM_CPUS*NUM_LINES-1:0] lmask_flat;

    pcb_addr_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
        .addr (bus_addr),
        .kind (dec_kind),
        .cpu  (dec_cpu),
        .hit  (dec_hit)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic sel;
        // Bank select for a write or read that hits this CPU.
        always_comb sel = dec_hit && (dec_cpu == CPU_SEL_W'(c));

        pcb_cpu_bank #(.NUM_LINES(NUM_LINES), .GROUP_W(GROUP_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_evt (edge_evt),
            .level_in (level_in),
            .wr_cause (bus_wr && sel && (dec_kind == KIND_CAUSE)),
            .wr_emask (bus_wr && sel && (dec_kind == KIND_EMASK)),
            .wr_lmask (bus_wr && sel && (dec_kind == KIND_LMASK)),
            .wdata    (bus_wdata),
            .cause    (cause_flat[c*NUM_LINES +: NUM_LINES]),
            .emask    (emask_flat[c*NUM_LINES +: NUM_LINES]),
            .lmask    (lmask_flat[c*NUM_LINES +: NUM_LINES]),
            .irq      (cpu_irq[c*NUM_GROUPS +: NUM_GROUPS])
        );
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (dec_hit && (dec_cpu == CPU_SEL_W'(c))) begin
                case (dec_kind)
                    KIND_CAUSE: bus_rdata = cause_flat[c*NUM_LINES +: NUM_LINES];
                    KIND_EMASK: bus_rdata = emask_flat[c*NUM_LINES +: NUM_LINES];
                    KIND_LMASK: bus_rdata = lmask_flat[c*NUM_LINES +: NUM_LINES];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/percpu_irq_bank_chk.sv
// Property checker for the per-CPU interrupt router, bound to the top.
// Assumes the flattened bank state is reachable by name inside the top.
module percpu_irq_bank_chk #(
    parameter int NUM_LINES = 32,
    parameter int NUM_CPUS  = 4,
    parameter int GROUP_W   = 8,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_W,
    localparam int IRQ_W      = NUM_CPUS * NUM_GROUPS
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_LINES-1:0]          edge_evt,
    input logic [NUM_LINES-1:0]          level_in,
    input logic                          bus_wr,
    input logic [5:0]                    bus_addr,
    input logic [NUM_LINES-1:0]          bus_rdata,
    input logic [IRQ_W-1:0]              cpu_irq,
    input logic [NUM_CPUS*NUM_LINES-1:0] cause_flat,
    input logic [NUM_CPUS*NUM_LINES-1:0] emask_flat,
    input logic [NUM_CPUS*NUM_LINES-1:0] lmask_flat
);
    logic [IRQ_W-1:0] want_irq;
    logic             unmapped;

    // Independent model of the grouped pending condition.
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                want_irq[c*NUM_GROUPS+g] =
                    |((level_in[g*GROUP_W +: GROUP_W] & lmask_flat[c*NUM_LINES+g*GROUP_W +: GROUP_W]) |
                      (cause_flat[c*NUM_LINES+g*GROUP_W +: GROUP_W] & emask_flat[c*NUM_LINES+g*GROUP_W +: GROUP_W]));
            end
        end
    end

    // Address classes that must read as zero.
    always_comb unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[5:4] == 2'b11) ||
                           (32'(bus_addr[3:2]) >= NUM_CPUS);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> cpu_irq == '0); // R1

    AST_EVENT_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt != '0 |=> (cause_flat & {NUM_CPUS{$past(edge_evt)}}) == {NUM_CPUS{$past(edge_evt)}}); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h00 && edge_evt != '0) |=>
        (cause_flat[NUM_LINES-1:0] & $past(edge_evt)) == $past(edge_evt)); // R5

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_iso
        AST_CLEAR_OWN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(cause_flat[c*NUM_LINES +: NUM_LINES]) & ~cause_flat[c*NUM_LINES +: NUM_LINES]) == '0) ||
                     ($past(bus_wr) && ($past(bus_addr) == 6'(c*4)))); // R4
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_irq == $past(want_irq)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> bus_rdata == '0); // R8
endmodule

bind percpu_irq_bank percpu_irq_bank_chk #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .GROUP_W(GROUP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_evt   (edge_evt),
    .level_in   (level_in),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .cpu_irq    (cpu_irq),
    .cause_flat (cause_flat),
    .emask_flat (emask_flat),
    .lmask_flat (lmask_flat)
);

// File: tb/percpu_irq_bank_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, output latency and the address map.
module percpu_irq_bank_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [31:0] evt;
        logic [31:0] lvl;
        logic [5:0]  raddr;
        logic [31:0] exp_rd;
        logic [15:0] exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'h10, 32'h0000_00FF, 32'h0, 32'h0, 6'h10, 32'h0000_00FF, 16'h0000, 4'd2},        // R2 emask cpu0
        '{1'b0, 6'h00, 32'h0, 32'h0000_0001, 32'h0, 6'h00, 32'h0000_0001, 16'h0001, 4'd6},        // R6 cpu0 group0
        '{1'b0, 6'h00, 32'h0, 32'h0100_0000, 32'h0, 6'h0C, 32'h0100_0001, 16'h0001, 4'd3},        // R3 all banks
        '{1'b1, 6'h28, 32'h0000_FF00, 32'h0, 32'h0000_0100, 6'h28, 32'h0000_FF00, 16'h0201, 4'd6},// R6 level cpu2
        '{1'b1, 6'h1C, 32'hFF00_0000, 32'h0, 32'h0, 6'h1C, 32'hFF00_0000, 16'h8001, 4'd6},        // R6 cpu3 group3
        '{1'b1, 6'h00, 32'hFFFF_FFFE, 32'h0, 32'h0, 6'h00, 32'h0100_0000, 16'h8000, 4'd4},        // R4 clear bit0
        '{1'b0, 6'h00, 32'h0, 32'h0, 32'h0, 6'h0C, 32'h0100_0001, 16'h8000, 4'd4},                // R4 other bank kept
        '{1'b1, 6'h0C, 32'hFEFF_FFFF, 32'h0100_0000, 32'h0, 6'h0C, 32'h0100_0001, 16'h8000, 4'd5},// R5 set wins
        '{1'b1, 6'h0C, 32'hFEFF_FFFF, 32'h0, 32'h0, 6'h0C, 32'h0000_0001, 16'h0000, 4'd4},        // R4 clear bit24
        '{1'b1, 6'h14, 32'hFFFF_FFFF, 32'h0, 32'h0, 6'h04, 32'h0100_0001, 16'h0090, 4'd6},        // R6 cpu1 groups 0,3
        '{1'b1, 6'h30, 32'hFFFF_FFFF, 32'h0, 32'h0, 6'h30, 32'h0000_0000, 16'h0090, 4'd8},        // R8 unmapped
        '{1'b1, 6'h11, 32'h0000_0000, 32'h0, 32'h0, 6'h14, 32'hFFFF_FFFF, 16'h0090, 4'd8},        // R8 misaligned
        '{1'b1, 6'h14, 32'h0000_0000, 32'h0, 32'h0000_0080, 6'h04, 32'h0100_0001, 16'h0000, 4'd9},// R9 masked, kept
        '{1'b1, 6'h14, 32'h0100_0000, 32'h0, 32'h0, 6'h04, 32'h0100_0001, 16'h0080, 4'd9}         // R9 unmask
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] edge_evt = '0;
    logic [31:0] level_in = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] cpu_irq;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    percpu_irq_bank u_percpu_irq_bank (
        .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .level_in(level_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reset_block();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; edge_evt = '0; level_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Every mapped register reads zero and no interrupt is raised.
    task automatic check_all_zero();
        for (int a = 0; a < 48; a += 4) begin
            bus_addr = 6'(a);
            #1;
            check("R1", bus_rdata, 32'h0);
        end
        check("R1", {16'h0, cpu_irq}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: state right after reset.
        reset_block();
        check_all_zero();

        // Vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bus_wr = VECS[i].wr; bus_addr = VECS[i].addr; bus_wdata = VECS[i].wdata;
            edge_evt = VECS[i].evt; level_in = VECS[i].lvl;
            @(negedge clk);
            bus_wr = 1'b0; edge_evt = '0; bus_addr = VECS[i].raddr;
            @(negedge clk);
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {16'h0, cpu_irq}, {16'h0, VECS[i].exp_irq});
        end

        // R7: level mask cpu0 bit0 with level high; irq lags by one cycle.
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h1; level_in = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 same cycle", {16'h0, cpu_irq}, 32'h0080);
        @(negedge clk);
        check("R7 next cycle", {16'h0, cpu_irq}, 32'h0081);

        // R1: reset in mid-run clears everything.
        reset_block();
        check_all_zero();

        // R2: distinct value into every mask register, then read all back.
        for (int a = 16; a < 48; a += 4) begin
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 32'hA500_0000 | 32'(a);
        end
        @(negedge clk);
        bus_wr = 1'b0;
        for (int a = 16; a < 48; a += 4) begin
            bus_addr = 6'(a);
            #1;
            check("R2 map", bus_rdata, 32'hA500_0000 | 32'(a));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule